// File: doc/BRIEF.md
# Reorder Buffer with Precise Retirement

This block is a circular queue that tracks in-flight instructions in their program order. The front end places an instruction into the queue at dispatch, before it executes. It supplies the instruction's program counter, its destination register and whether it writes that register. In return it gets a tag that names the slot. Execution units may finish in any order. Each one reports back with the tag, the result value and an optional fault with a cause code. The buffer records these facts in the tagged slot.

Retirement drains the oldest slot once it is complete. It drives a write port toward the architectural register file and updates an architectural program counter. As a result, both of these always reflect strictly sequential execution.

When the oldest slot is complete and faulting, the buffer does not retire it. Instead it reports the faulting program counter and cause on a one-cycle flush output, which the front end uses to restart. It also discards every younger slot. Each slot carries a generation bit that flips on every allocation. Completions addressed to discarded slots, or to an earlier use of a slot, therefore leave the new contents alone.

Top module: `rob_core`

## Requirements
- R1: After a synchronous active-high reset, `disp_ready` is 1, `ret_valid` and `flush_valid` are 0, and `arch_pc` equals the RESET_PC parameter (default 0).
- R2: `disp_tag` is `{gen, slot}`. The low log2(DEPTH) bits are the slot, and slots are handed out sequentially with wrap-around. The top bit is the slot's generation, which is 0 after reset and inverts on every allocation of that slot. With DEPTH=16, the first tag after reset is 5'h10.
- R3: Entries retire strictly in dispatch order. An entry retires only when it is complete and every older entry has retired. Later entries completing first causes no retirement.
- R4: At most one entry retires per cycle. A completion sampled at clock edge k lets its entry, if it is the oldest, appear on the retire port (`ret_valid` high for one cycle, carrying its pc, dst, write enable and result) after edge k+1, and not earlier.
- R5: `arch_pc` takes the pc of each retiring entry in the same cycle as `ret_valid`. It is unchanged by dispatch, completion or flush.
- R6: With DEPTH entries in flight, `disp_ready` is 0, and a dispatch offered then is ignored: no slot or tag is consumed.
- R7: A completion with its fault bit set marks the entry faulting. When that entry is the oldest, `flush_valid` pulses for one cycle with the entry's pc and cause. The entry does not retire, all younger entries are discarded and never retire, and dispatch is refused in the cycle the flush is decided.
- R8: A completion whose tag names an empty slot, or whose generation bit differs from the slot's current generation, has no effect.
- R9: A dispatch and a retirement in the same cycle leave the occupancy unchanged, so the full point is still reached after exactly DEPTH outstanding entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_pc | input | PC_W | Program counter of the dispatched instruction |
| disp_dst | input | REG_W | Destination register |
| disp_wen | input | 1 | Instruction writes its destination |
| disp_ready | output | 1 | Buffer can accept a dispatch this cycle |
| disp_tag | output | log2(DEPTH)+1 | Tag the next accepted dispatch receives |
| cmp_valid | input | 1 | Completion writeback valid |
| cmp_tag | input | log2(DEPTH)+1 | Tag of the completing entry |
| cmp_result | input | DATA_W | Result value |
| cmp_fault | input | 1 | Instruction faulted |
| cmp_cause | input | CAUSE_W | Fault cause code |
| ret_valid | output | 1 | One entry retired |
| ret_pc | output | PC_W | Program counter of the retired entry |
| ret_dst | output | REG_W | Register to write |
| ret_wen | output | 1 | Register write enable |
| ret_data | output | DATA_W | Value to write |
| arch_pc | output | PC_W | Architectural program counter |
| flush_valid | output | 1 | Flush and front-end restart |
| flush_pc | output | PC_W | Program counter of the faulting entry |
| flush_cause | output | CAUSE_W | Fault cause |

## Verification
Two pairs of events are made to land in the same cycle. In the first, a dispatch is issued in the exact cycle the oldest entry retires. The bench then fills the buffer and judges that `disp_ready` falls only after DEPTH further outstanding entries. In the second, a retirement is immediately followed by a faulting head. The bench checks that the flush cycle refuses dispatch and that the flush reports the right pc and cause. A scoreboard matches every retirement against the program-order list of entries expected to survive. Stale completions sent after the flush must not alter the entries that reuse those slots.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    HEAD_IDLE,
    HEAD_RETIRE,
    HEAD_FLUSH
  } head_act_e;

  function automatic head_act_e pick_head(input logic vld, input logic dn, input logic flt);
    if (vld && dn) return flt ? HEAD_FLUSH : HEAD_RETIRE;
    return HEAD_IDLE;
  endfunction

endpackage

// File: rtl/rob_flags.sv
module rob_flags #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             pop_en,
  input  logic [IDX_W-1:0] pop_idx,
  input  logic             flush_all,
  input  logic             cmp_en,
  input  logic [IDX_W-1:0] cmp_idx,
  input  logic             cmp_gen,
  input  logic             cmp_fault,
  output logic [DEPTH-1:0] valid_o,
  output logic [DEPTH-1:0] done_o,
  output logic [DEPTH-1:0] fault_o,
  output logic [DEPTH-1:0] gen_o,
  output logic             cmp_hit_o
);

  // a writeback lands only on a live, not yet finished slot of the same generation
  assign cmp_hit_o = cmp_en && valid_o[cmp_idx] && (gen_o[cmp_idx] == cmp_gen)
                     && !done_o[cmp_idx];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic v_q, d_q, f_q, g_q;
    logic sel_alloc, sel_pop, sel_cmp;

    assign sel_alloc = alloc_en && (alloc_idx == IDX_W'(gi));
    assign sel_pop   = pop_en   && (pop_idx   == IDX_W'(gi));
    assign sel_cmp   = cmp_hit_o && (cmp_idx  == IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        f_q <= 1'b0;
        g_q <= 1'b0;
      end else begin
        if (flush_all) begin
          v_q <= 1'b0;
        end else if (sel_alloc) begin
          v_q <= 1'b1;
          d_q <= 1'b0;
          f_q <= 1'b0;
          g_q <= ~g_q;
        end else if (sel_pop) begin
          v_q <= 1'b0;
        end
        if (sel_cmp) begin
          d_q <= 1'b1;
          f_q <= cmp_fault;
        end
      end
    end

    assign valid_o[gi] = v_q;
    assign done_o[gi]  = d_q;
    assign fault_o[gi] = f_q;
    assign gen_o[gi]   = g_q;
  end

endmodule

// File: rtl/rob_payload.sv
module rob_payload #(
  parameter int DEPTH   = 16,
  parameter int IDX_W   = 4,
  parameter int PC_W    = 32,
  parameter int DATA_W  = 32,
  parameter int REG_W   = 5,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               alloc_en,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic [PC_W-1:0]    alloc_pc,
  input  logic [REG_W-1:0]   alloc_dst,
  input  logic               alloc_wen,
  input  logic               wb_en,
  input  logic [IDX_W-1:0]   wb_idx,
  input  logic [DATA_W-1:0]  wb_result,
  input  logic [CAUSE_W-1:0] wb_cause,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [PC_W-1:0]    rd_pc,
  output logic [REG_W-1:0]   rd_dst,
  output logic               rd_wen,
  output logic [DATA_W-1:0]  rd_result,
  output logic [CAUSE_W-1:0] rd_cause
);

  logic [PC_W-1:0]    pc_mem    [DEPTH];
  logic [REG_W-1:0]   dst_mem   [DEPTH];
  logic               wen_mem   [DEPTH];
  logic [DATA_W-1:0]  res_mem   [DEPTH];
  logic [CAUSE_W-1:0] cause_mem [DEPTH];

  // dispatch-side fields
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      pc_mem[alloc_idx]  <= alloc_pc;
      dst_mem[alloc_idx] <= alloc_dst;
      wen_mem[alloc_idx] <= alloc_wen;
    end
  end

  // writeback-side fields
  always_ff @(posedge clk) begin
    if (wb_en) begin
      res_mem[wb_idx]   <= wb_result;
      cause_mem[wb_idx] <= wb_cause;
    end
  end

  assign rd_pc     = pc_mem[rd_idx];
  assign rd_dst    = dst_mem[rd_idx];
  assign rd_wen    = wen_mem[rd_idx];
  assign rd_result = res_mem[rd_idx];
  assign rd_cause  = cause_mem[rd_idx];

endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH   = 16,
  parameter int PC_W    = 32,
  parameter int DATA_W  = 32,
  parameter int REG_W   = 5,
  parameter int CAUSE_W = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TAG_W  = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               disp_valid,
  input  logic [PC_W-1:0]    disp_pc,
  input  logic [REG_W-1:0]   disp_dst,
  input  logic               disp_wen,
  output logic               disp_ready,
  output logic [TAG_W-1:0]   disp_tag,
  input  logic               cmp_valid,
  input  logic [TAG_W-1:0]   cmp_tag,
  input  logic [DATA_W-1:0]  cmp_result,
  input  logic               cmp_fault,
  input  logic [CAUSE_W-1:0] cmp_cause,
  output logic               ret_valid,
  output logic [PC_W-1:0]    ret_pc,
  output logic [REG_W-1:0]   ret_dst,
  output logic               ret_wen,
  output logic [DATA_W-1:0]  ret_data,
  output logic [PC_W-1:0]    arch_pc,
  output logic               flush_valid,
  output logic [PC_W-1:0]    flush_pc,
  output logic [CAUSE_W-1:0] flush_cause
);
  import rob_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [IDX_W-1:0] idx_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [IDX_W-1:0]   head_q, tail_q;
  logic [CNT_W-1:0]   count_q;
  logic [DEPTH-1:0]   valid_v, done_v, fault_v, gen_v;
  logic               cmp_hit, alloc;
  head_act_e          act;
  logic [PC_W-1:0]    head_pc;
  logic [REG_W-1:0]   head_dst;
  logic               head_wen;
  logic [DATA_W-1:0]  head_res;
  logic [CAUSE_W-1:0] head_cause;

  assign act        = pick_head(valid_v[head_q], done_v[head_q], fault_v[head_q]);
  assign disp_ready = (count_q != CNT_W'(DEPTH)) && (act != HEAD_FLUSH);
  assign alloc      = disp_valid && disp_ready;
  assign disp_tag   = {~gen_v[tail_q], tail_q};

  rob_flags #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_flags (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (alloc),
    .alloc_idx (tail_q),
    .pop_en    (act == HEAD_RETIRE),
    .pop_idx   (head_q),
    .flush_all (act == HEAD_FLUSH),
    .cmp_en    (cmp_valid),
    .cmp_idx   (cmp_tag[IDX_W-1:0]),
    .cmp_gen   (cmp_tag[IDX_W]),
    .cmp_fault (cmp_fault),
    .valid_o   (valid_v),
    .done_o    (done_v),
    .fault_o   (fault_v),
    .gen_o     (gen_v),
    .cmp_hit_o (cmp_hit)
  );

  rob_payload #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .PC_W(PC_W), .DATA_W(DATA_W),
    .REG_W(REG_W), .CAUSE_W(CAUSE_W)
  ) i_payload (
    .clk       (clk),
    .alloc_en  (alloc),
    .alloc_idx (tail_q),
    .alloc_pc  (disp_pc),
    .alloc_dst (disp_dst),
    .alloc_wen (disp_wen),
    .wb_en     (cmp_hit),
    .wb_idx    (cmp_tag[IDX_W-1:0]),
    .wb_result (cmp_result),
    .wb_cause  (cmp_cause),
    .rd_idx    (head_q),
    .rd_pc     (head_pc),
    .rd_dst    (head_dst),
    .rd_wen    (head_wen),
    .rd_result (head_res),
    .rd_cause  (head_cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q      <= '0;
      tail_q      <= '0;
      count_q     <= '0;
      ret_valid   <= 1'b0;
      ret_pc      <= '0;
      ret_dst     <= '0;
      ret_wen     <= 1'b0;
      ret_data    <= '0;
      arch_pc     <= RESET_PC;
      flush_valid <= 1'b0;
      flush_pc    <= '0;
      flush_cause <= '0;
    end else begin
      ret_valid   <= 1'b0;
      flush_valid <= 1'b0;
      if (act == HEAD_RETIRE) begin
        ret_valid <= 1'b1;
        ret_pc    <= head_pc;
        ret_dst   <= head_dst;
        ret_wen   <= head_wen;
        ret_data  <= head_res;
        arch_pc   <= head_pc;
        head_q    <= idx_inc(head_q);
      end
      if (act == HEAD_FLUSH) begin
        flush_valid <= 1'b1;
        flush_pc    <= head_pc;
        flush_cause <= head_cause;
        tail_q      <= head_q;
        count_q     <= '0;
      end else begin
        if (alloc) tail_q <= idx_inc(tail_q);
        count_q <= count_q + CNT_W'(alloc) - CNT_W'(act == HEAD_RETIRE);
      end
    end
  end

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             disp_ready,
  input logic             ret_valid,
  input logic [PC_W-1:0]  ret_pc,
  input logic [PC_W-1:0]  arch_pc,
  input logic             flush_valid,
  input logic [CNT_W-1:0] count
);

  a_r6_refuse_when_full: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_W'(DEPTH)) |-> !disp_ready);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  a_r5_arch_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !ret_valid |-> $stable(arch_pc));

  a_r5_arch_pc_match: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> (arch_pc == ret_pc));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (count == '0));

  a_r7_flush_no_retire: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> !ret_valid);

  a_r7_flush_pulse: assert property (@(posedge clk) disable iff (rst)
    flush_valid |=> !flush_valid);

endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .PC_W(PC_W), .CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .disp_ready  (disp_ready),
  .ret_valid   (ret_valid),
  .ret_pc      (ret_pc),
  .arch_pc     (arch_pc),
  .flush_valid (flush_valid),
  .count       (count_q)
);

// File: tb/test_rob_core.sv
module test_rob_core;

  localparam int DEPTH = 16;
  localparam int TAG_W = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        disp_valid = 1'b0;
  logic [31:0] disp_pc = '0;
  logic [4:0]  disp_dst = '0;
  logic        disp_wen = 1'b0;
  logic        disp_ready;
  logic [4:0]  disp_tag;
  logic        cmp_valid = 1'b0;
  logic [4:0]  cmp_tag = '0;
  logic [31:0] cmp_result = '0;
  logic        cmp_fault = 1'b0;
  logic [3:0]  cmp_cause = '0;
  logic        ret_valid;
  logic [31:0] ret_pc;
  logic [4:0]  ret_dst;
  logic        ret_wen;
  logic [31:0] ret_data;
  logic [31:0] arch_pc;
  logic        flush_valid;
  logic [31:0] flush_pc;
  logic [3:0]  flush_cause;

  always #4 clk = ~clk;

  rob_core i_rob_core (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_pc(disp_pc), .disp_dst(disp_dst), .disp_wen(disp_wen),
    .disp_ready(disp_ready), .disp_tag(disp_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_result(cmp_result),
    .cmp_fault(cmp_fault), .cmp_cause(cmp_cause),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_dst(ret_dst), .ret_wen(ret_wen),
    .ret_data(ret_data), .arch_pc(arch_pc),
    .flush_valid(flush_valid), .flush_pc(flush_pc), .flush_cause(flush_cause)
  );

  typedef struct {
    logic [31:0] pc;
    logic [4:0]  dst;
    logic        wen;
    logic [31:0] res;
  } ret_item_t;

  ret_item_t   ret_q[$];
  logic [31:0] flush_pc_q[$];
  logic [3:0]  flush_cause_q[$];

  int errors = 0;
  int checks = 0;
  int ret_seen = 0;
  int m_tail = 0;
  bit m_gen[DEPTH];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: offers one dispatch, predicts its tag and queues the expected retirement
  task automatic do_disp(input logic [31:0] pc, input logic [4:0] dst, input logic wen,
                         input logic [31:0] res, input bit survives, output logic [4:0] tag);
    ret_item_t it;
    disp_valid = 1'b1; disp_pc = pc; disp_dst = dst; disp_wen = wen;
    chk("R6", "ready before full", {31'b0, disp_ready}, 32'd1);
    m_gen[m_tail] = ~m_gen[m_tail];
    tag = {m_gen[m_tail], 4'(m_tail)};
    chk("R2", "dispatch tag", {27'b0, disp_tag}, {27'b0, tag});
    m_tail = (m_tail + 1) % DEPTH;
    if (survives) begin
      it.pc = pc; it.dst = dst; it.wen = wen; it.res = res;
      ret_q.push_back(it);
    end
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic do_cmp(input logic [4:0] tag, input logic [31:0] res, input logic flt,
                        input logic [3:0] cause);
    cmp_valid = 1'b1; cmp_tag = tag; cmp_result = res; cmp_fault = flt; cmp_cause = cause;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_fault = 1'b0;
  endtask

  // monitor: pops the scoreboard as the design retires or flushes
  always @(negedge clk) begin
    if (!rst) begin
      if (ret_valid) begin
        ret_item_t e;
        ret_seen++;
        if (ret_q.size() == 0) begin
          chk("R3", "retire with nothing expected", ret_pc, 32'hFFFF_FFFF);
        end else begin
          e = ret_q.pop_front();
          chk("R3", "retire pc order", ret_pc, e.pc);
          chk("R4", "retire data", ret_data, e.res);
          chk("R4", "retire dst", {27'b0, ret_dst}, {27'b0, e.dst});
          chk("R4", "retire wen", {31'b0, ret_wen}, {31'b0, e.wen});
          chk("R5", "arch pc follows retire", arch_pc, e.pc);
        end
      end
      if (flush_valid) begin
        if (flush_pc_q.size() == 0) begin
          chk("R7", "unexpected flush", flush_pc, 32'hFFFF_FFFF);
        end else begin
          chk("R7", "flush pc", flush_pc, flush_pc_q.pop_front());
          chk("R7", "flush cause", {28'b0, flush_cause}, {28'b0, flush_cause_q.pop_front()});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [4:0] t_a, t_b, t_c, t_d, t_e, t_g, t_h;
    logic [4:0] t_f1, t_f2, t_f3, t_f4;
    logic [4:0] tq[DEPTH];
    int base;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R2 first tag
    chk("R1", "disp_ready", {31'b0, disp_ready}, 32'd1);
    chk("R1", "ret_valid", {31'b0, ret_valid}, 32'd0);
    chk("R1", "flush_valid", {31'b0, flush_valid}, 32'd0);
    chk("R1", "arch_pc", arch_pc, 32'd0);
    chk("R2", "first tag", {27'b0, disp_tag}, 32'h10);

    // R3: completions in reverse order, retirement in program order
    do_disp(32'h100, 5'd1, 1'b1, 32'hA1, 1'b1, t_a);
    do_disp(32'h104, 5'd2, 1'b1, 32'hB2, 1'b1, t_b);
    do_disp(32'h108, 5'd3, 1'b0, 32'hC3, 1'b1, t_c);
    chk("R5", "arch pc after dispatch", arch_pc, 32'd0);
    do_cmp(t_c, 32'hC3, 1'b0, 4'd0);
    do_cmp(t_b, 32'hB2, 1'b0, 4'd0);
    repeat (3) @(negedge clk);
    chk("R3", "no retire while oldest pending", ret_seen, 0);
    chk("R5", "arch pc after completions", arch_pc, 32'd0);
    do_cmp(t_a, 32'hA1, 1'b0, 4'd0);
    repeat (5) @(negedge clk);
    chk("R3", "three retired", ret_seen, 3);
    chk("R5", "arch pc last retired", arch_pc, 32'h108);

    // R4: retirement timing after completion
    do_disp(32'h200, 5'd4, 1'b1, 32'hD4, 1'b1, t_d);
    do_cmp(t_d, 32'hD4, 1'b0, 4'd0);
    chk("R4", "no retire at first edge", {31'b0, ret_valid}, 32'd0);
    @(negedge clk);
    chk("R4", "retire at second edge", {31'b0, ret_valid}, 32'd1);
    @(negedge clk);
    chk("R4", "single cycle pulse", {31'b0, ret_valid}, 32'd0);

    // R9: dispatch in the retire cycle, then fill to exactly DEPTH
    do_disp(32'h300, 5'd5, 1'b1, 32'hE5, 1'b1, t_e);
    do_cmp(t_e, 32'hE5, 1'b0, 4'd0);
    do_disp(32'h304, 5'd6, 1'b1, 32'hF6, 1'b1, tq[0]);
    chk("R9", "retire beside dispatch", {31'b0, ret_valid}, 32'd1);
    for (int i = 1; i < DEPTH; i++)
      do_disp(32'h304 + 32'(4 * i), 5'(i), 1'b1, 32'hF00 + 32'(i), 1'b1, tq[i]);
    chk("R6", "full refuses", {31'b0, disp_ready}, 32'd0);
    chk("R9", "full after DEPTH", {31'b0, disp_ready}, 32'd0);
    disp_valid = 1'b1; disp_pc = 32'h999; disp_dst = 5'd9; disp_wen = 1'b1;
    @(negedge clk);
    disp_valid = 1'b0;
    base = ret_seen;
    do_cmp(tq[0], 32'hF6, 1'b0, 4'd0);
    for (int i = 1; i < DEPTH; i++) do_cmp(tq[i], 32'hF00 + 32'(i), 1'b0, 4'd0);
    repeat (6) @(negedge clk);
    chk("R6", "drained count", ret_seen - base, DEPTH);
    chk("R6", "ignored dispatch used no slot", {27'b0, disp_tag},
        {27'b0, ~m_gen[m_tail], 4'(m_tail)});

    // R7: fault at the second entry discards younger ones
    do_disp(32'h400, 5'd10, 1'b1, 32'h41, 1'b1, t_f1);
    do_disp(32'h404, 5'd11, 1'b1, 32'h42, 1'b0, t_f2);
    do_disp(32'h408, 5'd12, 1'b1, 32'h43, 1'b0, t_f3);
    do_disp(32'h40C, 5'd13, 1'b1, 32'h44, 1'b0, t_f4);
    flush_pc_q.push_back(32'h404);
    flush_cause_q.push_back(4'h5);
    do_cmp(t_f4, 32'h44, 1'b0, 4'd0);
    do_cmp(t_f3, 32'h43, 1'b0, 4'd0);
    do_cmp(t_f2, 32'h42, 1'b1, 4'h5);
    do_cmp(t_f1, 32'h41, 1'b0, 4'd0);
    @(negedge clk);
    chk("R7", "dispatch refused in flush cycle", {31'b0, disp_ready}, 32'd0);
    @(negedge clk);
    chk("R7", "flush pulse", {31'b0, flush_valid}, 32'd1);
    chk("R7", "ready after flush", {31'b0, disp_ready}, 32'd1);
    chk("R5", "flush keeps arch pc", arch_pc, 32'h400);
    m_tail = int'(t_f2[3:0]);
    repeat (3) @(negedge clk);
    chk("R5", "arch pc still held", arch_pc, 32'h400);

    // R8: stale completions to reused or empty slots are ignored
    base = ret_seen;
    do_disp(32'h500, 5'd7, 1'b1, 32'h77, 1'b1, t_g);
    do_disp(32'h504, 5'd8, 1'b1, 32'h88, 1'b1, t_h);
    do_cmp(t_f3, 32'hBAD, 1'b0, 4'd0);
    do_cmp(t_f2, 32'hBAD, 1'b1, 4'd3);
    do_cmp(t_f4, 32'hBAD, 1'b0, 4'd0);
    repeat (3) @(negedge clk);
    chk("R8", "stale tags complete nothing", ret_seen - base, 0);
    chk("R8", "no flush from stale fault", {31'b0, flush_valid}, 32'd0);
    do_cmp(t_h, 32'h88, 1'b0, 4'd0);
    do_cmp(t_g, 32'h77, 1'b0, 4'd0);
    repeat (5) @(negedge clk);
    chk("R8", "reused slots retire", ret_seen - base, 2);

    chk("R3", "scoreboard empty", ret_q.size(), 0);
    chk("R7", "flush list empty", flush_pc_q.size(), 0);
    finish_run();
  end

endmodule